// File: doc/BRIEF.md
# Double-Buffered 10-Bit PWM Generator

This block produces a pulse-width-modulated level on a single output. An 8-bit period timer, extended below by a 2-bit fine count, forms a 10-bit time base. The output rises at the start of each period and falls when the time base reaches the 10-bit duty value. The host programs three registers: period, upper duty bits, and control. The control register holds the two lower duty bits, the prescaler choice and the mode field. A clock-enable `tick` input paces all counting, and the prescaler stretches each fine step to 1, 4 or 16 ticks.

The duty value the host writes is only a staging copy. It moves into a shadow register at the boundary where the timer, having equalled the period value, steps back to zero. That shadow is the value compared and the value shown on `shadow_duty`, so a rewrite in mid-period cannot cut a pulse short or stretch it. A duty of zero keeps the output low for the whole period. A duty that the time base never reaches keeps the output high for the whole period.

A small controller sequences the block through three states. OFF holds the counters at zero and the output low. OFF goes to ARM once the mode field selects PWM. ARM goes to RUN on the next tick, and that tick performs the first period-start load. RUN goes back to OFF whenever the mode field stops selecting PWM, and so does ARM.

Top module: `pwm10_gen`

## Requirements
- R1: After reset `pwm_out` is 0 and `shadow_duty` is 0. The output stays 0 until the control register's mode field (bits 7:4) is written with 4'b1100.
- R2: Register address 0 sets the period value PR. In PWM mode the output rises at each period start, and one period lasts 4*(PR+1)*P ticks, where P is the prescale factor.
- R3: The duty D is {address 1 register, control bits 1:0}, with control bits 1:0 as the two least significant bits. The output stays high for D*P ticks of each period.
- R4: Writes to the duty registers leave `shadow_duty` and the running period unchanged. The new value is loaded into `shadow_duty` and takes effect only at the next period start.
- R5: When the duty loaded at a period start is 0, the output is not set and stays low for that period.
- R6: When the duty is 4*(PR+1) or more, the output is never cleared and stays high through every period.
- R7: Control bits 3:2 choose the prescale factor P: 2'b00 gives 1, 2'b01 gives 4, and 2'b10 or 2'b11 gives 16.
- R8: A control write whose mode field is not 4'b1100, such as writing zero, drives the output low on the following clock. The output remains low while the mode field stays off.
- R9: Counting advances only on cycles where `tick` is 1. With `tick` high on every other cycle, the high time and the period each double when measured in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable for all counting |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 upper duty, 2 control |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output level |
| shadow_duty | output | 10 | Active (latched) 10-bit duty value |

## Verification
The generator is run with several period and duty pairs at each prescale factor. A pair such as PR=9 with D=13 and D=39 shows that the high-time and period formulas are exact. The second of these leaves a single low step per period. Zero duty and duties at and far beyond 4*(PR+1) tell the suppressed-set case and the never-cleared case apart from ordinary edges. A duty rewrite made just after a period start shows the double buffering: the shadow keeps its old value, and the new high time appears only one period later. A gated `tick` separates tick counting from clock counting, and a mid-pulse write of zero to the control register shows the forced-low path.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

    localparam int PWM_FINE_W = 2;
    localparam int PWM_PS_W   = 2;
    localparam int PWM_MODE_W = 4;
    localparam int PWM_ADDR_W = 2;

    localparam logic [PWM_ADDR_W-1:0] ADDR_PERIOD  = 2'd0;
    localparam logic [PWM_ADDR_W-1:0] ADDR_DUTY_HI = 2'd1;
    localparam logic [PWM_ADDR_W-1:0] ADDR_CTRL    = 2'd2;

    localparam logic [PWM_MODE_W-1:0] MODE_PWM = 4'b1100;

    typedef struct packed {
        logic [PWM_MODE_W-1:0] mode;
        logic [PWM_PS_W-1:0]   ps_sel;
        logic [PWM_FINE_W-1:0] duty_lo;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ARM = 2'd1,
        ST_RUN = 2'd2
    } pwm_state_e;

endpackage

// File: rtl/pwm10_subcnt.sv
module pwm10_subcnt
    import pwm10_pkg::*;
#(
    parameter int PS_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  tick,
    input  logic                  clr,
    input  logic [PWM_PS_W-1:0]   ps_sel,
    output logic [PWM_FINE_W-1:0] fine_nx,
    output logic                  wrap
);

    localparam int SUB_W = PWM_FINE_W * (PS_STAGES + 1);

    logic [SUB_W-1:0] sub_q;
    logic [SUB_W-1:0] sub_inc;
    logic [SUB_W-1:0] sub_nx;
    logic [SUB_W-1:0] term;
    logic [SUB_W:0]   one_sh;
    logic             at_term;
    int               stage;

    // prescale codes above the last stage saturate to it (1x selects /16)
    always_comb begin
        if (int'(ps_sel) > PS_STAGES) begin
            stage = PS_STAGES;
        end else begin
            stage = int'(ps_sel);
        end
        one_sh  = (SUB_W+1)'(1) << (PWM_FINE_W * (stage + 1));
        term    = SUB_W'(one_sh - 1'b1);
        at_term = (sub_q == term);
        sub_inc = at_term ? '0 : sub_q + 1'b1;
        sub_nx  = tick ? sub_inc : sub_q;
        fine_nx = PWM_FINE_W'(sub_nx >> (PWM_FINE_W * stage));
        wrap    = run && tick && at_term;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q <= '0;
        end else if (!run || clr) begin
            sub_q <= '0;
        end else if (tick) begin
            sub_q <= sub_inc;
        end
    end

endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [TMR_W-1:0] period,
    output logic [TMR_W-1:0] tmr_q,
    output logic [TMR_W-1:0] tmr_nx,
    output logic             at_top
);

    always_comb begin
        at_top = (tmr_q == period);
        if (!step) begin
            tmr_nx = tmr_q;
        end else if (at_top) begin
            tmr_nx = '0;
        end else begin
            tmr_nx = tmr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (!run) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_nx;
        end
    end

endmodule

// File: rtl/pwm10_regs.sv
module pwm10_regs
    import pwm10_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [PWM_ADDR_W-1:0]       wr_addr,
    input  logic [TMR_W-1:0]            wr_data,
    output logic [TMR_W-1:0]            period_q,
    output logic [TMR_W+PWM_FINE_W-1:0] duty_buf,
    output logic                        mode_pwm,
    output logic [PWM_PS_W-1:0]         ps_sel,
    output logic                        ps_changed
);

    logic [TMR_W-1:0] duty_hi_q;
    ctrl_t            ctrl_q;
    ctrl_t            ctrl_in;
    logic             wr_ctrl;

    assign ctrl_in    = ctrl_t'(wr_data[CTRL_W-1:0]);
    assign wr_ctrl    = wr_en && (wr_addr == ADDR_CTRL);
    assign ps_changed = wr_ctrl && (ctrl_in.ps_sel != ctrl_q.ps_sel);
    assign duty_buf   = {duty_hi_q, ctrl_q.duty_lo};
    assign mode_pwm   = (ctrl_q.mode == MODE_PWM);
    assign ps_sel     = ctrl_q.ps_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q  <= '0;
            duty_hi_q <= '0;
            ctrl_q    <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_PERIOD:  period_q  <= wr_data;
                ADDR_DUTY_HI: duty_hi_q <= wr_data;
                ADDR_CTRL:    ctrl_q    <= ctrl_in;
                default:      ;
            endcase
        end
    end

endmodule

// File: rtl/pwm10_fsm.sv
module pwm10_fsm
    import pwm10_pkg::*;
#(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              mode_pwm,
    input  logic              wrap,
    input  logic              at_top,
    input  logic [DUTY_W-1:0] cnt_nx,
    input  logic [DUTY_W-1:0] duty_buf,
    output logic              run,
    output logic              load_evt,
    output logic              pwm_out,
    output logic [DUTY_W-1:0] shadow_q
);

    pwm_state_e state_q;
    pwm_state_e state_nx;
    logic       match_clr;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_OFF:  state_nx = mode_pwm ? ST_ARM : ST_OFF;
            ST_ARM:  state_nx = !mode_pwm ? ST_OFF : (tick ? ST_RUN : ST_ARM);
            ST_RUN:  state_nx = mode_pwm ? ST_RUN : ST_OFF;
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_nx;
        end
    end

    assign run       = (state_q == ST_RUN);
    assign load_evt  = mode_pwm &&
                       (((state_q == ST_ARM) && tick) || (run && wrap && at_top));
    assign match_clr = run && tick && (cnt_nx == shadow_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_out  <= 1'b0;
            shadow_q <= '0;
        end else if (!mode_pwm) begin
            pwm_out  <= 1'b0;
        end else if (load_evt) begin
            shadow_q <= duty_buf;
            pwm_out  <= (duty_buf != '0);
        end else if (match_clr) begin
            pwm_out  <= 1'b0;
        end
    end

endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
    import pwm10_pkg::*;
#(
    parameter int TMR_W     = 8,
    parameter int PS_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        wr_en,
    input  logic [PWM_ADDR_W-1:0]       wr_addr,
    input  logic [TMR_W-1:0]            wr_data,
    output logic                        pwm_out,
    output logic [TMR_W+PWM_FINE_W-1:0] shadow_duty
);

    localparam int DUTY_W = TMR_W + PWM_FINE_W;

    logic [TMR_W-1:0]      period_val;
    logic [DUTY_W-1:0]     buf_duty;
    logic                  mode_pwm;
    logic [PWM_PS_W-1:0]   ps_sel;
    logic                  ps_changed;
    logic [PWM_FINE_W-1:0] fine_nx;
    logic                  wrap;
    logic                  run;
    logic [TMR_W-1:0]      tmr_val;
    logic [TMR_W-1:0]      tmr_nx;
    logic                  at_top;
    logic                  load_evt;
    logic [DUTY_W-1:0]     cnt_nx;

    assign cnt_nx = {tmr_nx, fine_nx};

    pwm10_regs #(.TMR_W(TMR_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .period_q   (period_val),
        .duty_buf   (buf_duty),
        .mode_pwm   (mode_pwm),
        .ps_sel     (ps_sel),
        .ps_changed (ps_changed)
    );

    pwm10_subcnt #(.PS_STAGES(PS_STAGES)) i_subcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .clr     (ps_changed),
        .ps_sel  (ps_sel),
        .fine_nx (fine_nx),
        .wrap    (wrap)
    );

    pwm10_timebase #(.TMR_W(TMR_W)) i_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .step   (wrap),
        .period (period_val),
        .tmr_q  (tmr_val),
        .tmr_nx (tmr_nx),
        .at_top (at_top)
    );

    pwm10_fsm #(.DUTY_W(DUTY_W)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode_pwm (mode_pwm),
        .wrap     (wrap),
        .at_top   (at_top),
        .cnt_nx   (cnt_nx),
        .duty_buf (buf_duty),
        .run      (run),
        .load_evt (load_evt),
        .pwm_out  (pwm_out),
        .shadow_q (shadow_duty)
    );

endmodule

// File: rtl/pwm10_gen_chk.sv
module pwm10_gen_chk #(
    parameter int TMR_W  = 8,
    parameter int DUTY_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              pwm_out,
    input logic [DUTY_W-1:0] shadow_duty,
    input logic              load_evt,
    input logic [DUTY_W-1:0] buf_duty,
    input logic              mode_pwm,
    input logic [TMR_W-1:0]  tmr_val
);

    // shadow only moves at a period start
    p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_duty != $past(shadow_duty)) |-> $past(load_evt));

    // a period start with nonzero duty raises the output
    p_set_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_evt && (buf_duty != '0)) |=> pwm_out);

    // the output rises only at a period start
    p_rise_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> $past(load_evt));

    // zero duty suppresses the set
    p_zero_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_evt && (buf_duty == '0)) |=> !pwm_out);

    // leaving PWM mode forces the output low
    p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_pwm |=> !pwm_out);

    // period start restarts the timer
    p_timer_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_evt |=> (tmr_val == '0));

    // nothing moves on a cycle without tick while in PWM mode
    p_tick_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && mode_pwm) |=> ($stable(pwm_out) && $stable(tmr_val)));

endmodule

bind pwm10_gen pwm10_gen_chk #(.TMR_W(TMR_W), .DUTY_W(TMR_W + pwm10_pkg::PWM_FINE_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .pwm_out     (pwm_out),
    .shadow_duty (shadow_duty),
    .load_evt    (load_evt),
    .buf_duty    (buf_duty),
    .mode_pwm    (mode_pwm),
    .tmr_val     (tmr_val)
);

// File: tb/test_pwm10_gen.sv
`timescale 1ns/1ps
module test_pwm10_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       tick_gate = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_out;
    logic [9:0] shadow_duty;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tick = tick_gate ? ~tick : 1'b1;
        end
    end

    pwm10_gen i_pwm10_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .pwm_out     (pwm_out),
        .shadow_duty (shadow_duty)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input int pr, input int d, input logic [1:0] ps);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'(pr));
        wr(2'd1, 8'(d >> 2));
        wr(2'd2, {4'b1100, ps, 2'(d)});
    endtask

    task automatic wait_shadow(input int d);
        for (int g = 0; g < 20000; g++) begin
            if (int'(shadow_duty) == d) break;
            @(negedge clk);
        end
    endtask

    // waits for a rising edge, returns high and low lengths in clock cycles
    task automatic measure(output int hi, output int lo);
        logic prev;
        prev = pwm_out;
        hi = 0; lo = 0;
        for (int g = 0; g < 20000; g++) begin
            @(negedge clk);
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
        hi = 1;
        for (int g = 0; g < 20000; g++) begin
            @(negedge clk);
            if (pwm_out) hi++; else break;
        end
        lo = 1;
        for (int g = 0; g < 20000; g++) begin
            @(negedge clk);
            if (!pwm_out) lo++; else break;
        end
    endtask

    task automatic count_level(input int n, input logic lvl, output int bad);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out != lvl) bad++;
        end
    endtask

    task automatic t_reset();
        chk("R1 out after reset", int'(pwm_out), 0);
        chk("R1 shadow after reset", int'(shadow_duty), 0);
        rst_n = 1'b1;
        begin
            int bad;
            count_level(30, 1'b0, bad);
            chk("R1 idle low", bad, 0);
        end
    endtask

    task automatic t_basic();
        int hi, lo;
        setup(9, 13, 2'b00);
        wait_shadow(13);
        chk("R3 shadow loaded", int'(shadow_duty), 13);
        measure(hi, lo);
        chk("R3 high time D=13", hi, 13);
        chk("R2 period PR=9", hi + lo, 40);
        setup(9, 39, 2'b00);
        wait_shadow(39);
        measure(hi, lo);
        chk("R3 high time D=39", hi, 39);
        chk("R2 period PR=9 D=39", hi + lo, 40);
    endtask

    task automatic t_double_buffer();
        int hi, lo;
        setup(9, 13, 2'b00);
        wait_shadow(13);
        measure(hi, lo);
        wr(2'd1, 8'd5);
        wr(2'd2, {4'b1100, 2'b00, 2'd1});
        chk("R4 shadow held after write", int'(shadow_duty), 13);
        measure(hi, lo);
        chk("R4 new duty next period", hi, 21);
        chk("R4 shadow updated", int'(shadow_duty), 21);
    endtask

    task automatic t_zero();
        int hi, lo, bad;
        setup(9, 13, 2'b00);
        wait_shadow(13);
        measure(hi, lo);
        wr(2'd1, 8'd0);
        wr(2'd2, {4'b1100, 2'b00, 2'd0});
        wait_shadow(0);
        chk("R5 shadow zero", int'(shadow_duty), 0);
        count_level(100, 1'b0, bad);
        chk("R5 zero duty stays low", bad, 0);
    endtask

    task automatic t_long();
        int bad;
        setup(9, 1023, 2'b00);
        wait_shadow(1023);
        count_level(100, 1'b1, bad);
        chk("R6 duty 1023 stays high", bad, 0);
        setup(9, 40, 2'b00);
        wait_shadow(40);
        @(negedge clk);
        count_level(100, 1'b1, bad);
        chk("R6 duty 4*(PR+1) stays high", bad, 0);
    endtask

    task automatic t_prescale();
        int hi, lo;
        setup(3, 5, 2'b01);
        wait_shadow(5);
        measure(hi, lo);
        chk("R7 /4 high time", hi, 20);
        chk("R7 /4 period", hi + lo, 64);
        setup(1, 3, 2'b10);
        wait_shadow(3);
        measure(hi, lo);
        chk("R7 /16 high time", hi, 48);
        chk("R7 /16 period", hi + lo, 128);
        setup(1, 3, 2'b11);
        measure(hi, lo);
        chk("R7 code 11 high time", hi, 48);
        chk("R7 code 11 period", hi + lo, 128);
    endtask

    task automatic t_off();
        int hi, lo, bad;
        setup(9, 30, 2'b00);
        wait_shadow(30);
        measure(hi, lo);
        chk("R8 output high before off", int'(pwm_out), 1);
        wr(2'd2, 8'h00);
        @(negedge clk);
        chk("R8 forced low", int'(pwm_out), 0);
        count_level(60, 1'b0, bad);
        chk("R8 stays low", bad, 0);
    endtask

    task automatic t_tick();
        int hi, lo;
        tick_gate = 1'b1;
        setup(4, 6, 2'b00);
        wait_shadow(6);
        measure(hi, lo);
        chk("R9 gated high time", hi, 12);
        chk("R9 gated period", hi + lo, 40);
        tick_gate = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all requirements actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_double_buffer();
        t_zero();
        t_long();
        t_prescale();
        t_off();
        t_tick();
        finish_run();
    end

endmodule